// File: doc/BRIEF.md
# UART receiver with per-character error queue

This block receives asynchronous serial characters on one input line and delivers them through a two-entry receive queue that sits behind a single-character holding stage. Each queued character carries its own frame-error, overrun and parity-error flags. The outputs always show the character at the head of the queue together with that character's flags. A read strobe removes the head entry.

The sample clock comes from an internal divider: one sample tick every `baud_div + 1` clock cycles. A bit lasts 16 ticks, or 8 ticks when the double-speed input is high. Character size (5 to 9 data bits) and parity (none, even or odd) are configuration inputs. An address-filter mode, meant for one-master multi-drop links, makes the receiver drop every frame that is not marked as an address. The receive-complete interrupt is a plain AND of the queue-not-empty state, a local enable and a global enable. Lowering the enable input flushes everything and holds the receiver idle.

Top module: `serial_rx_errq`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then an optional marker bit, then an optional parity bit, then one stop bit. `char_size` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and values 4 to 7 select 9 bits. `rx_data` holds the data right-aligned, with zeros above the character size.
- R2: `frame_err` is 1 for the head character when its stop bit was sampled as 0, and 0 when the stop bit was 1.
- R3: `par_mode` 00 or 01 means no parity bit is sent and no parity check is made. 10 selects even parity and 11 selects odd parity, counted over the data bits, the marker bit (if present) and the parity bit. `parity_err` is 1 only when checking was on for that character and the count came out wrong. Parity mode, size and address mode are taken at each character's start bit.
- R4: The queue holds two characters in arrival order. The status outputs follow the head entry. `rd_pop` removes the head. A pop on an empty queue has no effect. All data and flag outputs read 0 while the queue is empty.
- R5: A completed character waits in the holding stage while the queue is full. It enters the queue in the same cycle that a pop frees an entry, so it is visible one cycle after that pop.
- R6: An overrun occurs when a start bit is validated while the queue is full, a character is waiting in the holding stage, and no pop occurs in that same cycle. The waiting character then carries `overrun` = 1, and the character whose start bit caused the overrun is discarded.
- R7: The divider makes one sample tick every `baud_div + 1` clock cycles. A bit lasts 16 ticks when `dbl_speed` = 0 and 8 ticks when `dbl_speed` = 1. Each bit value is the majority of three samples around the middle of the bit.
- R8: A start bit is accepted only if the majority of its three middle samples is 0. A low pulse that fails this vote returns the receiver to idle and queues nothing.
- R9: When `mpc_mode` = 1, a frame of 5 to 8 data bits carries a marker bit after its data bits, and a 9-bit frame uses data bit 8 as the marker. Frames whose marker is 0 are dropped. When `mpc_mode` = 0, no marker bit is sent and every frame is accepted.
- R10: While `rx_en` = 0, the queue, the holding stage and the receiver are cleared. From the next cycle, `rx_valid` and all flags read 0.
- R11: `rx_irq` is 1 exactly when `rxc_ie`, `gie` and `rx_valid` are all 1.
- R12: After reset, `rx_valid`, `rx_irq`, `rx_data` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; 0 flushes the receiver |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| baud_div | input | DIV_W | Sample tick period minus one, in clock cycles |
| par_mode | input | 2 | 0x none, 10 even, 11 odd |
| char_size | input | 3 | Data bits: 0..3 give 5..8 bits, 4..7 give 9 bits |
| mpc_mode | input | 1 | Address-filter mode |
| rxd | input | 1 | Serial receive line, idle high |
| rd_pop | input | 1 | Remove the head character |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rx_data | output | 9 | Head character data |
| rx_valid | output | 1 | Queue not empty (receive complete) |
| frame_err | output | 1 | Head character stop bit was 0 |
| overrun | output | 1 | A character was lost after the head character |
| parity_err | output | 1 | Head character failed its parity check |
| rx_irq | output | 1 | Receive-complete interrupt |

## Verification
The two events that can fall in the same cycle are a read strobe that frees a queue entry and the validation of a new start bit while the queue and holding stage are both full. The bench fills the queue and holding stage, then starts one more frame. It sweeps the cycle of a single pop across a window that spans the start-bit vote. For each offset it reads everything out and checks that the outcome is self-consistent: either the waiting character has no overrun flag and the new character is delivered, or the flag is set and the new character is gone. It also checks that once an overrun appears at some offset it appears at every later offset, and that both outcomes occur within the window.

// File: rtl/serial_rx_errq.sv
module serial_rx_errq #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             dbl_speed,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       par_mode,
  input  logic [2:0]       char_size,
  input  logic             mpc_mode,
  input  logic             rxd,
  input  logic             rd_pop,
  input  logic             rxc_ie,
  input  logic             gie,
  output logic [8:0]       rx_data,
  output logic             rx_valid,
  output logic             frame_err,
  output logic             overrun,
  output logic             parity_err,
  output logic             rx_irq
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t              st;
  logic             rx_m, rx_q;
  logic [DIV_W-1:0] divc;
  logic [3:0]       scnt, bidx, c_n;
  logic [1:0]       vote, c_par, cnt;
  logic             c_mpc, lose, sh_addr, sh_x;
  logic [8:0]       sh_data;
  logic             hold_v;
  logic [11:0]      hold_e, ent0, ent1;

  wire       tick       = (divc == '0);
  wire [3:0] last_s     = dbl_speed ? 4'd7 : 4'd15;
  wire [3:0] vote_s     = dbl_speed ? 4'd5 : 4'd9;
  wire       maj        = (vote[0] & vote[1]) | (vote[0] & rx_q) | (vote[1] & rx_q);
  wire       at_vote    = tick && (scnt == vote_s);
  wire       pop        = rd_pop && (cnt != 2'd0);
  wire       full_now   = hold_v && (cnt == 2'd2) && !pop;
  wire       start_ok   = (st == S_START) && at_vote && !maj;
  wire       ovr        = start_ok && full_now;
  wire       frame_done = (st == S_STOP) && at_vote;
  wire [3:0] n_sel      = char_size[2] ? 4'd9 : {2'b00, char_size[1:0]} + 4'd5;
  wire       mark_bit   = c_mpc && (c_n != 4'd9);
  wire [3:0] last_b     = c_n + {3'b000, mark_bit} + {3'b000, c_par[1]} - 4'd1;
  wire       is_addr    = (c_n == 4'd9) ? sh_data[8] : sh_addr;
  wire       keep       = frame_done && !lose && (!c_mpc || is_addr);
  wire       move       = hold_v && ((cnt != 2'd2) || pop);
  wire [1:0] cnt_p      = cnt - {1'b0, pop};
  wire [11:0] new_e     = {1'b0, c_par[1] & (sh_x ^ c_par[0]), ~maj, sh_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_q <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      divc <= '0;
    else if (!rx_en) divc <= '0;
    else if (tick)   divc <= baud_div;
    else             divc <= divc - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scnt <= '0; bidx <= '0; vote <= 2'b11;
      c_n <= 4'd8; c_par <= '0; c_mpc <= 1'b0; lose <= 1'b0;
      sh_data <= '0; sh_addr <= 1'b0; sh_x <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE; scnt <= '0; bidx <= '0; vote <= 2'b11; lose <= 1'b0;
    end else if (tick) begin
      vote <= {vote[0], rx_q};
      case (st)
        S_IDLE: if (!rx_q) begin
          st   <= S_START;
          scnt <= 4'd1;
        end
        S_START: begin
          if (at_vote && maj) st <= S_IDLE;
          else if (scnt == last_s) begin
            st   <= S_DATA;
            scnt <= '0;
          end else scnt <= scnt + 4'd1;
          if (start_ok) begin
            c_n     <= n_sel;
            c_par   <= par_mode;
            c_mpc   <= mpc_mode;
            lose    <= full_now;
            sh_data <= '0;
            sh_addr <= 1'b0;
            sh_x    <= 1'b0;
            bidx    <= '0;
          end
        end
        S_DATA: begin
          if (at_vote) begin
            sh_x <= sh_x ^ maj;
            if (bidx < c_n) sh_data <= sh_data | (9'(maj) << bidx);
            else if (bidx == c_n && mark_bit) sh_addr <= maj;
          end
          if (scnt == last_s) begin
            scnt <= '0;
            if (bidx == last_b) st <= S_STOP;
            else bidx <= bidx + 4'd1;
          end else scnt <= scnt + 4'd1;
        end
        S_STOP: begin
          if (at_vote) st <= S_IDLE;
          else scnt <= scnt + 4'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_e <= '0; ent0 <= '0; ent1 <= '0; cnt <= '0;
    end else if (!rx_en) begin
      hold_v <= 1'b0; hold_e <= '0; ent0 <= '0; ent1 <= '0; cnt <= '0;
    end else begin
      if (move) hold_v <= 1'b0;
      else if (keep) begin
        hold_v <= 1'b1;
        hold_e <= new_e;
      end
      if (ovr) hold_e[11] <= 1'b1;
      if (pop) ent0 <= ent1;
      if (move) begin
        if (cnt_p == 2'd0) ent0 <= hold_e;
        else ent1 <= hold_e;
      end
      cnt <= cnt_p + {1'b0, move};
    end
  end

  assign rx_valid = (cnt != 2'd0);
  assign {overrun, parity_err, frame_err, rx_data} = rx_valid ? ent0 : 12'h000;
  assign rx_irq = rxc_ie & gie & rx_valid;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  // R4
  fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(hold_v));

  // R5
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && hold_v && cnt == 2'd2 && !rd_pop) |=> hold_v);

  // R5
  done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && frame_done && !lose) |-> !hold_v);

  // R6
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_e[11]) |-> (hold_v && cnt == 2'd2));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (cnt == 2'd0 && !hold_v && st == S_IDLE));

endmodule

// File: tb/tb_serial_rx_errq.sv
module tb_serial_rx_errq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        dbl_speed = 1'b0;
  logic [11:0] baud_div = 12'd1;
  logic [1:0]  par_mode = 2'b00;
  logic [2:0]  char_size = 3'd3;
  logic        mpc_mode = 1'b0;
  logic        rxd = 1'b1;
  logic        rd_pop = 1'b0;
  logic        rxc_ie = 1'b0;
  logic        gie = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, frame_err, overrun, parity_err, rx_irq;

  int n_tests = 0;
  int n_fail  = 0;

  logic [11:0] mq [2];
  int          mcnt = 0;
  bit          mh_v = 1'b0;
  logic [11:0] mh = '0;

  always #2 clk = ~clk;

  serial_rx_errq #(.DIV_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed),
    .baud_div(baud_div), .par_mode(par_mode), .char_size(char_size),
    .mpc_mode(mpc_mode), .rxd(rxd), .rd_pop(rd_pop), .rxc_ie(rxc_ie),
    .gie(gie), .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .overrun(overrun), .parity_err(parity_err), .rx_irq(rx_irq)
  );

  task automatic clk_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ent(input logic [8:0] d, input int n,
      input logic [1:0] pm, input bit corrupt, input bit stopb);
    logic [8:0] m;
    m = 9'((1 << n) - 1);
    return {1'b0, pm[1] & corrupt, ~stopb, d & m};
  endfunction

  task automatic model_push(input logic [11:0] e);
    if (mcnt < 2) begin mq[mcnt] = e; mcnt++; end
    else begin mh_v = 1'b1; mh = e; end
  endtask

  task automatic model_pop();
    if (mcnt == 0) return;
    mq[0] = mq[1];
    mcnt--;
    if (mh_v) begin mq[mcnt] = mh; mcnt++; mh_v = 1'b0; end
  endtask

  task automatic model_flush();
    mcnt = 0; mh_v = 1'b0;
  endtask

  task automatic check_head(input string tag);
    logic [12:0] act, exp;
    act = {rx_valid, overrun, parity_err, frame_err, rx_data};
    exp = (mcnt != 0) ? {1'b1, mq[0]} : 13'h0;
    chk(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic pulse_pop();
    rd_pop = 1'b1;
    clk_wait(1);
    rd_pop = 1'b0;
    clk_wait(1);
  endtask

  task automatic do_pop(input string tag);
    check_head(tag);
    pulse_pop();
    model_pop();
    check_head(tag);
  endtask

  task automatic flush();
    rx_en = 1'b0;
    clk_wait(2);
    rx_en = 1'b1;
    model_flush();
    clk_wait(1);
  endtask

  task automatic send_raw(input logic [8:0] d, input int n, input logic [1:0] pm,
      input bit mpc, input bit addr, input bit corrupt, input bit stopb,
      input bit dbl, input int bd);
    logic [15:0] fr;
    int nb, bc;
    bit x;
    char_size = 3'(n - 5); par_mode = pm; mpc_mode = mpc;
    dbl_speed = dbl; baud_div = 12'(bd);
    clk_wait(2);
    bc = (bd + 1) * (dbl ? 8 : 16);
    fr = '0; nb = 1; x = 1'b0;
    for (int i = 0; i < n; i++) begin fr[nb] = d[i]; x ^= d[i]; nb++; end
    if (mpc && n < 9) begin fr[nb] = addr; x ^= addr; nb++; end
    if (pm[1]) begin fr[nb] = x ^ pm[0] ^ corrupt; nb++; end
    fr[nb] = stopb; nb++;
    for (int i = 0; i < nb; i++) begin rxd = fr[i]; clk_wait(bc); end
    rxd = 1'b1;
    clk_wait(2 * bc);
  endtask

  task automatic send(input logic [8:0] d, input int n, input logic [1:0] pm,
      input bit mpc, input bit addr, input bit corrupt, input bit stopb,
      input bit dbl, input int bd);
    bit lost, acc;
    lost = (mcnt == 2) && mh_v;
    if (lost) mh[11] = 1'b1;
    send_raw(d, n, pm, mpc, addr, corrupt, stopb, dbl, bd);
    acc = !mpc || ((n == 9) ? d[8] : addr);
    if (!lost && acc) model_push(exp_ent(d, n, pm, corrupt, stopb));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: R4 run did not end, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    bit prev_dor, saw_keep, saw_lose, dor;
    logic [8:0] a, b, c, dd;
    unused_seed = $urandom(32'h5eed);
    clk_wait(3);
    // R12 reset state
    chk({rx_valid, rx_irq, frame_err, overrun, parity_err, rx_data} == 14'h0,
        "R12 reset outputs", int'({rx_valid, rx_irq, rx_data}), 0);
    rst_n = 1'b1;
    clk_wait(2);
    rx_en = 1'b1;
    clk_wait(2);
    check_head("R12 empty after enable");

    // R1 sizes, R7 both oversampling rates
    send(9'h1A5, 9, 2'b00, 0, 0, 0, 1, 0, 1);
    do_pop("R1 nine-bit data");
    send(9'h1FF, 5, 2'b00, 0, 0, 0, 1, 1, 2);
    do_pop("R1 R7 five-bit masked at 8x");
    send(9'h05A, 8, 2'b00, 0, 0, 0, 1, 1, 1);
    do_pop("R7 double speed eight-bit");

    // R2 frame error
    send(9'h033, 8, 2'b00, 0, 0, 0, 0, 0, 1);
    chk(frame_err == 1'b1, "R2 stop low sets frame_err", frame_err, 1);
    do_pop("R2 frame error entry");

    // R3 parity
    send(9'h071, 7, 2'b10, 0, 0, 1, 1, 0, 1);
    chk(parity_err == 1'b1, "R3 even parity mismatch", parity_err, 1);
    do_pop("R3 even bad");
    send(9'h071, 7, 2'b11, 0, 0, 0, 1, 0, 1);
    chk(parity_err == 1'b0, "R3 odd parity correct", parity_err, 0);
    do_pop("R3 odd good");
    send(9'h071, 7, 2'b01, 0, 0, 1, 1, 0, 1);
    do_pop("R3 parity off no check");

    // R8 glitch rejection
    rxd = 1'b0; clk_wait(3); rxd = 1'b1; clk_wait(64);
    check_head("R8 glitch queues nothing");
    send(9'h0C3, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    do_pop("R8 frame after glitch");

    // R9 address filter
    send(9'h044, 8, 2'b00, 1, 0, 0, 1, 0, 1);
    check_head("R9 data frame dropped");
    send(9'h044, 8, 2'b10, 1, 1, 0, 1, 0, 1);
    do_pop("R9 address frame kept");
    send(9'h0AA, 9, 2'b00, 1, 0, 0, 1, 0, 1);
    check_head("R9 nine-bit non-address dropped");
    send(9'h1AA, 9, 2'b00, 1, 1, 0, 1, 0, 1);
    do_pop("R9 nine-bit address kept");
    send(9'h0AA, 9, 2'b00, 0, 0, 0, 1, 0, 1);
    do_pop("R9 filter off accepts all");

    // R11 interrupt gating
    send(9'h012, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 4; i++) begin
      rxc_ie = i[0]; gie = i[1]; clk_wait(1);
      chk(rx_irq == (i[0] & i[1]), "R11 irq gating", rx_irq, i[0] & i[1]);
    end
    do_pop("R11 drain");
    chk(rx_irq == 1'b0, "R11 no irq when empty", rx_irq, 0);

    // R5 R6 overrun directed
    send(9'h011, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    send(9'h022, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    send(9'h033, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    check_head("R5 head is first");
    send(9'h044, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    do_pop("R5 first");
    do_pop("R5 second");
    chk(overrun == 1'b1, "R6 overrun on waiting char", overrun, 1);
    do_pop("R6 waiting char");
    pulse_pop();
    check_head("R4 pop on empty ignored");

    // R10 flush
    send(9'h055, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    send(9'h066, 8, 2'b00, 0, 0, 0, 0, 0, 1);
    send(9'h077, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    rx_en = 1'b0; clk_wait(1);
    chk({rx_valid, frame_err, overrun, parity_err} == 4'h0, "R10 flush clears",
        int'({rx_valid, frame_err, overrun, parity_err}), 0);
    rx_en = 1'b1; model_flush(); clk_wait(1);
    send(9'h088, 8, 2'b00, 0, 0, 0, 1, 0, 1);
    do_pop("R10 fresh after flush");
    check_head("R10 nothing stale");

    // random mix: R1 R2 R3 R4 R6 R7 R9
    for (int f = 0; f < 40; f++) begin
      int n, bd, np;
      logic [8:0] d;
      logic [1:0] pm;
      bit cor, stb, mpc, adr, dbl;
      n = 5 + int'($urandom % 5); d = 9'($urandom); pm = 2'($urandom);
      cor = ($urandom % 4) == 0; stb = ($urandom % 8) != 0;
      mpc = ($urandom % 4) == 0; adr = 1'($urandom); dbl = 1'($urandom);
      bd = 1 + int'($urandom % 2);
      if (n == 9) adr = d[8];
      send(d, n, pm, mpc, adr, cor, stb, dbl, bd);
      check_head("R1 R2 R3 R4 R9 random frame");
      np = int'($urandom % 3);
      for (int p = 0; p < np; p++) do_pop("R4 R6 random pop");
    end

    // R6 same-cycle sweep of pop against start validation
    prev_dor = 1'b0; saw_keep = 1'b0; saw_lose = 1'b0;
    for (int k = 10; k <= 34; k++) begin
      flush();
      a = 9'($urandom % 256); b = 9'($urandom % 256);
      c = 9'($urandom % 256); dd = 9'($urandom % 256);
      send(a, 8, 2'b00, 0, 0, 0, 1, 0, 1);
      send(b, 8, 2'b00, 0, 0, 0, 1, 0, 1);
      send(c, 8, 2'b00, 0, 0, 0, 1, 0, 1);
      fork
        send_raw(dd, 8, 2'b00, 0, 0, 0, 1, 0, 1);
        begin clk_wait(2 + k); rd_pop = 1'b1; clk_wait(1); rd_pop = 1'b0; end
      join
      chk(rx_valid && rx_data == b, "R5 sweep second char", int'(rx_data), int'(b));
      pulse_pop();
      chk(rx_valid && rx_data == c, "R5 sweep third char", int'(rx_data), int'(c));
      dor = overrun;
      pulse_pop();
      if (dor) begin
        saw_lose = 1'b1;
        chk(!rx_valid, "R6 lost char absent", rx_valid, 0);
      end else begin
        saw_keep = 1'b1;
        chk(rx_valid && rx_data == dd && !overrun, "R6 kept char present",
            int'({rx_valid, rx_data}), int'({1'b1, dd}));
      end
      chk(!(prev_dor && !dor), "R6 overrun monotonic in offset", dor, 1);
      prev_dor = dor;
    end
    chk(saw_keep && saw_lose, "R6 both outcomes in window",
        int'({saw_keep, saw_lose}), 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule